// File: doc/BRIEF.md
# Buck Regulator Startup and Fault Supervisor

This block is the digital sequencer of a multiphase buck controller. It takes the outputs of analog comparators that have already been reduced to logic levels: supply above its undervoltage limit, the enable pin, output inside the power-good window, current limit active, delay capacitor below its shutdown threshold, output overvoltage, and output back under the overvoltage release level. From these it decides when the phases may switch and what the delay capacitor pin does. It also decides when the PWM lines are pulled low to discharge an overvoltage, and when an external crowbar is signalled.

Every comparator input is asynchronous to the controller clock and passes through its own synchronizer chain first. The sequencer is a six-state machine. Its states are held off, ramping up, regulating, riding a current limit while the delay node decays, shut down after the limit lasted too long, and crowbarred. Every output is a decode of the state register, so the outputs never glitch and always agree with each other.

Top module: `vr_start_supervisor`

## Requirements
- R1: While rst_n is low at a clock edge, the state is cleared. After reset the outputs show the held-off pattern: dly_discharge=1, drv_disable=1, and every other output 0.
- R2: Each comparator input passes through SYNC_STAGES synchronizer flops (default 2). An input change therefore reaches the outputs SYNC_STAGES+1 rising edges after it was applied, and not earlier.
- R3: Whenever supply_ok or en is low, the block returns to held-off from any state. In held-off, pwm_run, ss_ramp_en, dly_pullup, force_low and crowbar are 0, while dly_discharge and drv_disable are 1.
- R4: From held-off, with both supply_ok and en high, soft start begins. In soft start, pwm_run=1 and ss_ramp_en=1, and all other outputs are 0. During soft start, ilim_hit and dly_low have no effect.
- R5: In soft start, pgood high moves the block to regulating. There, pwm_run=1 and dly_pullup=1, and all other outputs are 0.
- R6: In regulating, ilim_hit high moves the block to the limit state. There, only pwm_run=1, so switching continues while the delay pull-up is released.
- R7: In the limit state, dly_low high moves the block to latched-off, even if ilim_hit clears in the same cycle. In latched-off, only drv_disable=1.
- R8: In the limit state, if ilim_hit clears without dly_low, the block goes to regulating when pgood is high and back to soft start when pgood is low.
- R9: ovp high in soft start, regulating or limit moves the block to crowbar, ahead of any other transition. In crowbar, force_low=1 and crowbar=1, and all other outputs are 0.
- R10: Crowbar is left only when ovp_clear is high and ovp is low. The block then goes to regulating if pgood is high, or to soft start if it is low.
- R11: Latched-off ignores pgood, ilim_hit, ovp, ovp_clear and dly_low. It is left only when supply_ok or en goes low, and a new soft start follows once both are high again.
- R12: At most one of ss_ramp_en, dly_pullup and dly_discharge is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | Supply above undervoltage lockout threshold (async) |
| en | input | 1 | Enable pin level (async) |
| pgood | input | 1 | Output inside power-good window (async) |
| ilim_hit | input | 1 | Current limit amplifier engaged (async) |
| dly_low | input | 1 | Delay node below shutdown threshold (async) |
| ovp | input | 1 | Output above power-good upper limit (async) |
| ovp_clear | input | 1 | Output below crowbar release level (async) |
| pwm_run | output | 1 | Phases may switch |
| ss_ramp_en | output | 1 | Delay node charge current on (soft-start ramp) |
| dly_pullup | output | 1 | Delay node pulled to its high level |
| dly_discharge | output | 1 | Delay node shorted to ground |
| drv_disable | output | 1 | Current-limit/driver-disable line clamped low |
| force_low | output | 1 | All PWM lines driven low |
| crowbar | output | 1 | Crowbar flag to external protection |

## Verification
Directed sequences cover every state transition. Some inputs change alone, which shows that each transition has exactly one cause. Others change together: ilim_hit clearing at the same moment dly_low rises shows latch-off winning over recovery. ovp arriving with ilim_hit shows crowbar winning over limit. ovp_clear raised while ovp stays high shows that release needs both conditions. Stimulus that has no effect is also applied: current limit during soft start, and all fault inputs toggled while latched off. A latency probe samples one cycle before and on the cycle of the expected response. A long run with weighted random inputs then brings up simultaneous and rapid changes, and the behavioural model judges every cycle.

// File: rtl/sup_pkg.sv
// Package: shared state encoding and input bundle for the startup supervisor.
// Assumes: the bundle bit order is used by the synchronizer as a plain vector.
package sup_pkg;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_SOFT  = 3'd1,
        ST_RUN   = 3'd2,
        ST_LIMIT = 3'd3,
        ST_LATCH = 3'd4,
        ST_CROW  = 3'd5
    } sup_state_e;

    typedef struct packed {
        logic supply_ok;
        logic en;
        logic pgood;
        logic ilim;
        logic dly_low;
        logic ovp;
        logic ovp_clr;
    } sup_in_t;

    localparam int unsigned SUP_IN_W = $bits(sup_in_t);

endpackage

// File: rtl/sup_sync.sv
// Module: multi-bit synchronizer chain, one flop column per stage.
// Assumes: each bit is an independent level signal, so no coherency across bits is needed.
module sup_sync #(
    parameter int unsigned WIDTH  = 7,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    // Shift the raw levels through the synchronizer columns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign q = stage_q[LAST];

endmodule

// File: rtl/sup_fsm.sv
// Module: sequencing state machine for enable, soft start, run, limit latch-off and crowbar.
// Assumes: inputs are already synchronized; overvoltage outranks every other transition,
// and loss of supply or enable outranks overvoltage.
module sup_fsm
    import sup_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  sup_in_t    in_s,
    output sup_state_e state_q
);
    sup_state_e state_d;
    logic       power_valid;
    sup_state_e resume_st;

    // Both supply and enable must be valid for any activity.
    assign power_valid = in_s.supply_ok & in_s.en;
    // Recovery target from limit or crowbar depends on power-good.
    assign resume_st   = in_s.pgood ? ST_RUN : ST_SOFT;

    // Next-state selection with overvoltage priority inside the active states.
    always_comb begin
        state_d = state_q;
        if (!power_valid) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:   state_d = ST_SOFT;
                ST_SOFT: begin
                    if (in_s.ovp)        state_d = ST_CROW;
                    else if (in_s.pgood) state_d = ST_RUN;
                end
                ST_RUN: begin
                    if (in_s.ovp)       state_d = ST_CROW;
                    else if (in_s.ilim) state_d = ST_LIMIT;
                end
                ST_LIMIT: begin
                    if (in_s.ovp)          state_d = ST_CROW;
                    else if (in_s.dly_low) state_d = ST_LATCH;
                    else if (!in_s.ilim)   state_d = resume_st;
                end
                ST_LATCH: state_d = ST_LATCH;
                ST_CROW: begin
                    if (in_s.ovp_clr && !in_s.ovp) state_d = resume_st;
                end
                default:  state_d = ST_OFF;
            endcase
        end
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    a_r3_invalid_power_goes_off: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_s.supply_ok && in_s.en) |=> state_q == ST_OFF);

    a_r4_off_starts_ramp: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && in_s.supply_ok && in_s.en) |=> state_q == ST_SOFT);

    a_r7_latch_beats_recovery: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LIMIT && in_s.supply_ok && in_s.en && !in_s.ovp && in_s.dly_low)
        |=> state_q == ST_LATCH);

    a_r9_ovp_enters_crowbar: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_SOFT || state_q == ST_RUN || state_q == ST_LIMIT)
         && in_s.supply_ok && in_s.en && in_s.ovp) |=> state_q == ST_CROW);

    a_r11_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LATCH && in_s.supply_ok && in_s.en) |=> state_q == ST_LATCH);

endmodule

// File: rtl/sup_outdec.sv
// Module: decodes the supervisor state into pin controls.
// Assumes: outputs are pure functions of the registered state, so they are glitch-free.
module sup_outdec
    import sup_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  sup_state_e state_q,
    output logic       pwm_run,
    output logic       ss_ramp_en,
    output logic       dly_pullup,
    output logic       dly_discharge,
    output logic       drv_disable,
    output logic       force_low,
    output logic       crowbar
);
    // Map each state to its control pattern.
    always_comb begin
        pwm_run       = 1'b0;
        ss_ramp_en    = 1'b0;
        dly_pullup    = 1'b0;
        dly_discharge = 1'b0;
        drv_disable   = 1'b0;
        force_low     = 1'b0;
        crowbar       = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                dly_discharge = 1'b1;
                drv_disable   = 1'b1;
            end
            ST_SOFT: begin
                pwm_run    = 1'b1;
                ss_ramp_en = 1'b1;
            end
            ST_RUN: begin
                pwm_run    = 1'b1;
                dly_pullup = 1'b1;
            end
            ST_LIMIT: pwm_run = 1'b1;
            ST_LATCH: drv_disable = 1'b1;
            ST_CROW: begin
                force_low = 1'b1;
                crowbar   = 1'b1;
            end
            default: begin
                dly_discharge = 1'b1;
                drv_disable   = 1'b1;
            end
        endcase
    end

    a_r12_delay_controls_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ss_ramp_en, dly_pullup, dly_discharge}));

    a_r9_crowbar_stops_switching: assert property (@(posedge clk) disable iff (!rst_n)
        crowbar |-> (!pwm_run && force_low));

endmodule

// File: rtl/vr_start_supervisor.sv
// Module: top of the regulator startup and fault supervisor.
// Assumes: all comparator inputs are asynchronous levels; SYNC_STAGES >= 1.
module vr_start_supervisor
    import sup_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic en,
    input  logic pgood,
    input  logic ilim_hit,
    input  logic dly_low,
    input  logic ovp,
    input  logic ovp_clear,
    output logic pwm_run,
    output logic ss_ramp_en,
    output logic dly_pullup,
    output logic dly_discharge,
    output logic drv_disable,
    output logic force_low,
    output logic crowbar
);
    sup_in_t    raw_in;
    sup_in_t    sync_in;
    sup_state_e state_q;

    // Bundle the raw comparator levels.
    assign raw_in = '{supply_ok: supply_ok, en: en, pgood: pgood, ilim: ilim_hit,
                      dly_low: dly_low, ovp: ovp, ovp_clr: ovp_clear};

    sup_sync #(
        .WIDTH  (SUP_IN_W),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (sync_in)
    );

    sup_fsm fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_s    (sync_in),
        .state_q (state_q)
    );

    sup_outdec dec_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .state_q       (state_q),
        .pwm_run       (pwm_run),
        .ss_ramp_en    (ss_ramp_en),
        .dly_pullup    (dly_pullup),
        .dly_discharge (dly_discharge),
        .drv_disable   (drv_disable),
        .force_low     (force_low),
        .crowbar       (crowbar)
    );

endmodule

// File: tb/vr_start_supervisor_tb_top.sv
module vr_start_supervisor_tb_top;
    localparam int STAGES = 2;
    localparam int LAT    = STAGES + 1;

    // model state codes
    localparam int M_OFF = 0, M_SOFT = 1, M_RUN = 2, M_LIMIT = 3, M_LATCH = 4, M_CROW = 5;

    // output vector {pwm_run, ss_ramp_en, dly_pullup, dly_discharge, drv_disable, force_low, crowbar}
    localparam logic [6:0] P_OFF   = 7'b0001100;
    localparam logic [6:0] P_SOFT  = 7'b1100000;
    localparam logic [6:0] P_RUN   = 7'b1010000;
    localparam logic [6:0] P_LIMIT = 7'b1000000;
    localparam logic [6:0] P_LATCH = 7'b0000100;
    localparam logic [6:0] P_CROW  = 7'b0000011;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 0, en = 0, pgood = 0, ilim_hit = 0, dly_low = 0, ovp = 0, ovp_clear = 0;
    logic pwm_run, ss_ramp_en, dly_pullup, dly_discharge, drv_disable, force_low, crowbar;

    int n_cmp = 0;
    int n_bad = 0;
    bit started = 0;
    bit done = 0;
    int m_state = M_OFF;
    logic [6:0] mq[$];

    always #10 clk = ~clk;

    vr_start_supervisor #(.SYNC_STAGES(STAGES)) dut_i (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .en(en), .pgood(pgood),
        .ilim_hit(ilim_hit), .dly_low(dly_low), .ovp(ovp), .ovp_clear(ovp_clear),
        .pwm_run(pwm_run), .ss_ramp_en(ss_ramp_en), .dly_pullup(dly_pullup),
        .dly_discharge(dly_discharge), .drv_disable(drv_disable),
        .force_low(force_low), .crowbar(crowbar));

    function automatic logic [6:0] pat_of(int s);
        case (s)
            M_SOFT:  return P_SOFT;
            M_RUN:   return P_RUN;
            M_LIMIT: return P_LIMIT;
            M_LATCH: return P_LATCH;
            M_CROW:  return P_CROW;
            default: return P_OFF;
        endcase
    endfunction

    function automatic string tag_of(int s);
        case (s)
            M_SOFT:  return "R4";
            M_RUN:   return "R5";
            M_LIMIT: return "R6";
            M_LATCH: return "R7";
            M_CROW:  return "R9";
            default: return "R3";
        endcase
    endfunction

    function automatic logic [6:0] dut_out();
        return {pwm_run, ss_ramp_en, dly_pullup, dly_discharge, drv_disable, force_low, crowbar};
    endfunction

    // Behavioural reference: delay queue of input snapshots, then a transition table.
    always @(posedge clk) begin
        logic [6:0] v;
        bit so, e, pg, il, dl, ov, oc;
        if (!rst_n) begin
            mq = {};
            for (int i = 0; i < STAGES; i++) mq.push_front(7'b0);
            m_state = M_OFF;
        end else begin
            v = mq[$];
            void'(mq.pop_back());
            mq.push_front({supply_ok, en, pgood, ilim_hit, dly_low, ovp, ovp_clear});
            {so, e, pg, il, dl, ov, oc} = v;
            if (!(so && e)) m_state = M_OFF;
            else if (m_state == M_OFF) m_state = M_SOFT;
            else if ((m_state == M_SOFT || m_state == M_RUN || m_state == M_LIMIT) && ov) m_state = M_CROW;
            else if (m_state == M_SOFT && pg) m_state = M_RUN;
            else if (m_state == M_RUN && il) m_state = M_LIMIT;
            else if (m_state == M_LIMIT && dl) m_state = M_LATCH;
            else if (m_state == M_LIMIT && !il) m_state = pg ? M_RUN : M_SOFT;
            else if (m_state == M_CROW && oc && !ov) m_state = pg ? M_RUN : M_SOFT;
        end
        started = 1;
    end

    // Every-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        logic [6:0] o;
        if (started && !done) begin
            o = dut_out();
            n_cmp++;
            if (o !== pat_of(m_state)) begin
                n_bad++;
                $display("FAIL %s per-cycle: actual %b expected %b", tag_of(m_state), o, pat_of(m_state));
            end
            n_cmp++;
            if (!$onehot0(o[5:3])) begin
                n_bad++;
                $display("FAIL R12 delay controls: actual %b expected at most one set", o[5:3]);
            end
        end
    end

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(string req, logic [6:0] exp);
        logic [6:0] o;
        o = dut_out();
        n_cmp++;
        if (o !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, o, exp);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        expect_out("R1 after reset", P_OFF);
        supply_ok = 1; wait_n(LAT);
        expect_out("R3 enable low holds off", P_OFF);
        en = 1; wait_n(LAT - 1);
        expect_out("R2 no early response", P_OFF);
        wait_n(1);
        expect_out("R2 R4 soft start at latency", P_SOFT);
        ilim_hit = 1; dly_low = 1; wait_n(LAT);
        expect_out("R4 limit ignored in soft start", P_SOFT);
        ilim_hit = 0; dly_low = 0;
        pgood = 1; wait_n(LAT);
        expect_out("R5 run", P_RUN);
        ilim_hit = 1; wait_n(LAT);
        expect_out("R6 limit", P_LIMIT);
        ilim_hit = 0; wait_n(LAT);
        expect_out("R8 recover to run", P_RUN);
        ilim_hit = 1; wait_n(LAT);
        expect_out("R6 limit again", P_LIMIT);
        ilim_hit = 0; pgood = 0; wait_n(LAT);
        expect_out("R8 recover to soft start", P_SOFT);
        pgood = 1; wait_n(LAT);
        expect_out("R5 run again", P_RUN);
        ilim_hit = 1; wait_n(LAT);
        expect_out("R6 limit third", P_LIMIT);
        ilim_hit = 0; dly_low = 1; wait_n(LAT);
        expect_out("R7 latch beats recovery", P_LATCH);
        dly_low = 0; ilim_hit = 1; ovp = 1; ovp_clear = 1; pgood = 0; wait_n(LAT + 2);
        expect_out("R11 latched ignores faults", P_LATCH);
        en = 0; wait_n(LAT);
        expect_out("R11 enable low clears latch", P_OFF);
        ilim_hit = 0; ovp = 0; ovp_clear = 0; pgood = 0;
        en = 1; wait_n(LAT);
        expect_out("R11 restart after toggle", P_SOFT);
        ovp = 1; wait_n(LAT);
        expect_out("R9 crowbar from soft start", P_CROW);
        ovp_clear = 1; wait_n(LAT);
        expect_out("R10 crowbar holds while ovp", P_CROW);
        ovp = 0; wait_n(LAT);
        expect_out("R10 release to soft start", P_SOFT);
        ovp_clear = 0; pgood = 1; wait_n(LAT);
        expect_out("R5 run before crowbar", P_RUN);
        ovp = 1; ilim_hit = 1; wait_n(LAT);
        expect_out("R9 crowbar beats limit", P_CROW);
        ovp = 0; ilim_hit = 0; ovp_clear = 1; wait_n(LAT);
        expect_out("R10 release to run", P_RUN);
        ovp_clear = 0;
        supply_ok = 0; wait_n(LAT);
        expect_out("R3 supply loss", P_OFF);
        supply_ok = 1; wait_n(LAT);
        expect_out("R4 restart after supply", P_SOFT);

        for (int k = 0; k < 4000; k++) begin
            supply_ok = ($urandom_range(0, 63) != 0);
            en        = ($urandom_range(0, 63) != 0);
            if ($urandom_range(0, 3) == 0) pgood     = ~pgood;
            if ($urandom_range(0, 4) == 0) ilim_hit  = ~ilim_hit;
            if ($urandom_range(0, 5) == 0) dly_low   = ~dly_low;
            if ($urandom_range(0, 7) == 0) ovp       = ~ovp;
            if ($urandom_range(0, 3) == 0) ovp_clear = ~ovp_clear;
            wait_n(1);
        end
        finish_run();
    end

endmodule